// File: doc/BRIEF.md
# Programmable Reference Frequency Divider

The divider turns the crystal-domain clock of a tuning synthesizer into the reference tick that drives the loop's phase comparator. Two select fields choose the result. One field names the crystal fitted to the board. The other names the wanted reference frequency. The divide ratio is the crystal frequency over the reference frequency. Every crystal/reference pair has its ratio computed at elaboration from the crystal frequency parameters.

One reference code stands for standby rather than for a frequency. Two codes can be produced only by the 4.5 MHz crystal, and asking for them with any other crystal raises an invalid flag. In standby or in an invalid pairing the outputs stay low.

The select fields come from a register loaded over a serial bus and are sampled every clock. A change in either field restarts the count at once, so that no partial period built from the old ratio reaches the comparator. The crystal enable gates the count without disturbing the selects.

Top module: `ref_div_top`

## Requirements
- R1: While rst_ni is low the block shows its power-on state whatever the select inputs are. standby_o is 1, invalid_o is 0, and ref_stb_o and ref_sq_o are 0. The held selection is crystal 3.6 MHz with the standby code.
- R2: Crystal select xtal_sel_i is 0=3.6 MHz, 1=4.5 MHz, 2=7.2 MHz, 3=10.8 MHz. Reference code ref_code_i, as an unsigned value, is 0=0.5, 1=1, 2=2.5, 3=3, 4=3.125, 5=3.90625, 6=5, 7=6.25, 8=7.8125, 9=9, 10=10, 11=12.5, 12=25, 13=50 and 14=100 kHz. With xtal_en_i held high, ref_stb_o pulses once every crystal/reference clocks.
- R3: ref_stb_o is high for exactly one clock per period.
- R4: In each period ref_sq_o is high for floor(ratio/2) clocks, and those clocks end at the clock that carries the strobe.
- R5: Code 15 is standby. standby_o is 1, and from the second clock of standby on, ref_stb_o and ref_sq_o are 0.
- R6: A clock edge with xtal_en_i low neither advances the count nor strobes, so each such edge lengthens the current period by one clock. Toggling xtal_en_i during standby leaves standby_o at 1 and the outputs low.
- R7: Codes 5 and 8 are legal only with crystal select 1. With any other crystal, invalid_o is 1 and the outputs stay low. standby_o and invalid_o are never 1 together.
- R8: A change in either select field restarts the count. There is no strobe in the two clocks after the change, and the first strobe comes exactly ratio+2 clocks after the change.
- R9: standby_o and invalid_o reflect a new selection one clock after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Crystal-domain clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| xtal_en_i | input | 1 | Count enable for the crystal domain |
| xtal_sel_i | input | 2 | Crystal type select |
| ref_code_i | input | 4 | Reference frequency code, 15 = standby |
| ref_stb_o | output | 1 | One-clock reference strobe |
| ref_sq_o | output | 1 | Near-square reference output |
| standby_o | output | 1 | Standby code selected |
| invalid_o | output | 1 | Code not producible with the selected crystal |

## Verification
A wrong ratio-table entry or a bad code decode shows as a strobe period that differs from crystal/reference. It is seen one period after the selection is applied. A broken restart path moves the first strobe away from ratio+2 clocks, or lets a stale strobe through just after the change. Wrong flag decoding appears on standby_o or invalid_o one clock after the selects move. A counter that ignores the enable shows as a period that fails to stretch by the number of disabled clocks.

// File: rtl/ref_div_pkg.sv
package ref_div_pkg;
  localparam int unsigned NUM_XTAL = 4;
  localparam int unsigned XSEL_W   = 2;
  localparam int unsigned CODE_W   = 4;
  localparam int unsigned NUM_CODE = 1 << CODE_W;

  localparam logic [CODE_W-1:0] CODE_STANDBY = '1;
  localparam logic [XSEL_W-1:0] XTAL_DEFAULT = 2'd0;
  localparam logic [XSEL_W-1:0] XTAL_ALT     = 2'd1;

  // reference frequency in quarter-hertz units, 0 for standby
  function automatic longint unsigned ref_qhz(input logic [CODE_W-1:0] code);
    case (code)
      4'd0:    return 64'd2000;
      4'd1:    return 64'd4000;
      4'd2:    return 64'd10000;
      4'd3:    return 64'd12000;
      4'd4:    return 64'd12500;
      4'd5:    return 64'd15625;
      4'd6:    return 64'd20000;
      4'd7:    return 64'd25000;
      4'd8:    return 64'd31250;
      4'd9:    return 64'd36000;
      4'd10:   return 64'd40000;
      4'd11:   return 64'd50000;
      4'd12:   return 64'd100000;
      4'd13:   return 64'd200000;
      4'd14:   return 64'd400000;
      default: return 64'd0;
    endcase
  endfunction

  function automatic longint unsigned div_ratio(input longint unsigned xhz,
                                                input logic [CODE_W-1:0] code);
    longint unsigned q;
    q = ref_qhz(code);
    if (q == 0) return 64'd1;
    return (xhz * 64'd4) / q;
  endfunction

  function automatic logic needs_alt_xtal(input logic [CODE_W-1:0] code);
    return (code == 4'd5) || (code == 4'd8);
  endfunction
endpackage

// File: rtl/ref_div_decode.sv
module ref_div_decode
  import ref_div_pkg::*;
#(
  parameter int unsigned CNT_W    = 15,
  parameter int unsigned XTAL0_HZ = 3_600_000,
  parameter int unsigned XTAL1_HZ = 4_500_000,
  parameter int unsigned XTAL2_HZ = 7_200_000,
  parameter int unsigned XTAL3_HZ = 10_800_000
) (
  input  logic [XSEL_W-1:0] xsel_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [CNT_W-1:0]  ratio_m1_o,
  output logic [CNT_W-1:0]  half_o,
  output logic              standby_o,
  output logic              invalid_o
);
  logic [CNT_W-1:0] rm1_tab  [NUM_XTAL][NUM_CODE];
  logic [CNT_W-1:0] half_tab [NUM_XTAL][NUM_CODE];

  for (genvar gx = 0; gx < NUM_XTAL; gx++) begin : g_xtal
    localparam longint unsigned XHZ = (gx == 0) ? XTAL0_HZ :
                                      (gx == 1) ? XTAL1_HZ :
                                      (gx == 2) ? XTAL2_HZ : XTAL3_HZ;
    for (genvar gc = 0; gc < NUM_CODE; gc++) begin : g_code
      localparam logic [63:0] RATIO = div_ratio(XHZ, CODE_W'(gc));
      localparam logic [63:0] RM1   = RATIO - 64'd1;
      localparam logic [63:0] RH    = RATIO >> 1;
      assign rm1_tab[gx][gc]  = RM1[CNT_W-1:0];
      assign half_tab[gx][gc] = RH[CNT_W-1:0];
    end
  end

  assign ratio_m1_o = rm1_tab[xsel_i][code_i];
  assign half_o     = half_tab[xsel_i][code_i];
  assign standby_o  = (code_i == CODE_STANDBY);
  assign invalid_o  = needs_alt_xtal(code_i) && (xsel_i != XTAL_ALT);

  always_comb begin
    p_flags_excl_r7: assert (!(standby_o && invalid_o));
  end
endmodule

// File: rtl/ref_div_counter.sv
module ref_div_counter #(
  parameter int unsigned CNT_W = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             active_i,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] ratio_m1_i,
  input  logic [CNT_W-1:0] half_i,
  output logic             stb_o,
  output logic             sq_o
);
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             stb_nxt, sq_nxt;

  always_comb begin
    cnt_nxt = cnt_q;
    stb_nxt = 1'b0;
    sq_nxt  = sq_o;
    if (!active_i || restart_i) begin
      cnt_nxt = ratio_m1_i;
      sq_nxt  = 1'b0;
    end else if (en_i) begin
      if (cnt_q == '0) begin
        cnt_nxt = ratio_m1_i;
        stb_nxt = 1'b1;
      end else begin
        cnt_nxt = cnt_q - 1'b1;
      end
      sq_nxt = (cnt_nxt < half_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      stb_o <= 1'b0;
      sq_o  <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      stb_o <= stb_nxt;
      sq_o  <= sq_nxt;
    end
  end

  p_stb_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_o && (ratio_m1_i != '0) |=> !stb_o);
  p_freeze_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_i && !restart_i && !en_i |=> !stb_o && $stable(cnt_q) && $stable(sq_o));
  p_idle_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> !stb_o && !sq_o);
  p_restart_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> !stb_o);
endmodule

// File: rtl/ref_div_top.sv
module ref_div_top
  import ref_div_pkg::*;
#(
  parameter int unsigned CNT_W    = 15,
  parameter int unsigned XTAL0_HZ = 3_600_000,
  parameter int unsigned XTAL1_HZ = 4_500_000,
  parameter int unsigned XTAL2_HZ = 7_200_000,
  parameter int unsigned XTAL3_HZ = 10_800_000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       xtal_en_i,
  input  logic [1:0] xtal_sel_i,
  input  logic [3:0] ref_code_i,
  output logic       ref_stb_o,
  output logic       ref_sq_o,
  output logic       standby_o,
  output logic       invalid_o
);
  logic [XSEL_W-1:0] xsel_q;
  logic [CODE_W-1:0] code_q;
  logic              restart_q, sel_chg;
  logic [CNT_W-1:0]  ratio_m1, half;

  assign sel_chg = (xtal_sel_i != xsel_q) || (ref_code_i != code_q);

  // power-on: 3.6 MHz crystal, standby code
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      xsel_q    <= XTAL_DEFAULT;
      code_q    <= CODE_STANDBY;
      restart_q <= 1'b0;
    end else begin
      xsel_q    <= xtal_sel_i;
      code_q    <= ref_code_i;
      restart_q <= sel_chg;
    end
  end

  ref_div_decode #(
    .CNT_W(CNT_W), .XTAL0_HZ(XTAL0_HZ), .XTAL1_HZ(XTAL1_HZ),
    .XTAL2_HZ(XTAL2_HZ), .XTAL3_HZ(XTAL3_HZ)
  ) u_decode (
    .xsel_i     (xsel_q),
    .code_i     (code_q),
    .ratio_m1_o (ratio_m1),
    .half_o     (half),
    .standby_o  (standby_o),
    .invalid_o  (invalid_o)
  );

  // first cycle reloads on the old ratio, the second on the new one
  ref_div_counter #(.CNT_W(CNT_W)) u_counter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (xtal_en_i),
    .active_i   (!standby_o && !invalid_o),
    .restart_i  (sel_chg || restart_q),
    .ratio_m1_i (ratio_m1),
    .half_i     (half),
    .stb_o      (ref_stb_o),
    .sq_o       (ref_sq_o)
  );

  p_standby_follow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_code_i == CODE_STANDBY) |=> standby_o);
  p_standby_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_o && $past(standby_o) |-> !ref_stb_o && !ref_sq_o);
  p_invalid_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    invalid_o && $past(invalid_o) |-> !ref_stb_o && !ref_sq_o);
endmodule

// File: tb/ref_div_top_tb.sv
module ref_div_top_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       xtal_en = 1'b1;
  logic [1:0] xtal_sel = 2'd2;
  logic [3:0] ref_code = 4'd3;
  logic       ref_stb, ref_sq, standby, invalid;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ref_div_top u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .xtal_en_i(xtal_en),
    .xtal_sel_i(xtal_sel), .ref_code_i(ref_code),
    .ref_stb_o(ref_stb), .ref_sq_o(ref_sq),
    .standby_o(standby), .invalid_o(invalid)
  );

  // {xtal, code, expected ratio}
  localparam int NV = 15;
  localparam logic [21:0] VEC [NV] = '{
    {2'd0, 4'd14, 16'd36},    {2'd1, 4'd13, 16'd90},
    {2'd2, 4'd12, 16'd288},   {2'd3, 4'd11, 16'd864},
    {2'd1, 4'd8,  16'd576},   {2'd1, 4'd5,  16'd1152},
    {2'd0, 4'd9,  16'd400},   {2'd3, 4'd10, 16'd1080},
    {2'd2, 4'd6,  16'd1440},  {2'd1, 4'd1,  16'd4500},
    {2'd0, 4'd4,  16'd1152},  {2'd3, 4'd0,  16'd21600},
    {2'd0, 4'd7,  16'd576},   {2'd2, 4'd3,  16'd2400},
    {2'd1, 4'd2,  16'd1800}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=<190000", cycles);
      summary();
    end
  end

  // negedges until the strobe is seen, starting one negedge on
  task automatic first_stb(input int lim, output int k);
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!ref_stb && k < lim);
  endtask

  // from a strobe to the next: period and square-high count
  task automatic period(input int lim, output int per, output int sqh);
    per = 0;
    sqh = 0;
    do begin
      @(negedge clk);
      per++;
      sqh += int'(ref_sq);
    end while (!ref_stb && per < lim);
  endtask

  task automatic select_run(input logic [1:0] x, input logic [3:0] c, input int r);
    int k, per, sqh;
    @(negedge clk);
    xtal_sel = x;
    ref_code = c;
    @(negedge clk);
    chk("R9", "standby after select", int'(standby), 0);
    chk("R7", "invalid on legal pair", int'(invalid), 0);
    chk("R8", "no stale strobe", int'(ref_stb), 0);
    k = 1;
    while (!ref_stb && k < r + 10) begin
      @(negedge clk);
      k++;
    end
    chk("R8", "clocks to first strobe", k, r + 2);
    period(r + 10, per, sqh);
    chk("R2", $sformatf("period x%0d c%0d", x, c), per, r);
    chk("R4", "square high clocks", sqh, r / 2);
    @(negedge clk);
    chk("R3", "strobe width", int'(ref_stb), 0);
  endtask

  initial begin
    int k, per, sqh, bad;
    // R1: power-on state held in reset despite non-default selects
    repeat (3) @(negedge clk);
    chk("R1", "standby in reset", int'(standby), 1);
    chk("R1", "invalid in reset", int'(invalid), 0);
    chk("R1", "strobe in reset", int'(ref_stb), 0);
    chk("R1", "square in reset", int'(ref_sq), 0);
    xtal_sel = 2'd0;
    ref_code = 4'd15;
    @(negedge clk);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++)
      select_run(VEC[i][21:20], VEC[i][19:16], int'(VEC[i][15:0]));

    // R6: disabled edges stretch the period one-for-one
    select_run(2'd0, 4'd14, 36);
    first_stb(50, k);
    repeat (5) @(negedge clk);
    xtal_en = 1'b0;
    repeat (7) @(negedge clk);
    xtal_en = 1'b1;
    per = 12;
    do begin
      @(negedge clk);
      per++;
    end while (!ref_stb && per < 100);
    chk("R6", "stretched period", per, 36 + 7);

    // R5 and R6: standby, enable toggled inside it
    @(negedge clk);
    ref_code = 4'd15;
    @(negedge clk);
    chk("R9", "standby one clock after code 15", int'(standby), 1);
    bad = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (i % 10 == 0) xtal_en = ~xtal_en;
      if (ref_stb || ref_sq || !standby || invalid) bad++;
    end
    xtal_en = 1'b1;
    chk("R5", "standby outputs low", bad, 0);
    chk("R6", "standby kept while enable toggles", int'(standby), 1);

    // R7: codes 5 and 8 with crystals other than select 1
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      xtal_sel = (i == 1) ? 2'd2 : (i == 2) ? 2'd3 : 2'd0;
      ref_code = (i % 2 == 0) ? 4'd5 : 4'd8;
      @(negedge clk);
      chk("R9", "invalid one clock after select", int'(invalid), 1);
      chk("R7", "standby clear when invalid", int'(standby), 0);
      bad = 0;
      for (int j = 0; j < 1000; j++) begin
        @(negedge clk);
        if (ref_stb || ref_sq || !invalid) bad++;
      end
      chk("R7", "invalid pair outputs low", bad, 0);
    end

    // R8: leave an invalid pair by changing only the crystal
    select_run(2'd1, 4'd8, 576);

    // R1: reset again mid-run
    rst_ni = 1'b0;
    @(negedge clk);
    chk("R1", "standby after re-reset", int'(standby), 1);
    chk("R1", "strobe after re-reset", int'(ref_stb), 0);

    done = 1'b1;
    summary();
  end
endmodule